// File: doc/BRIEF.md
# Keypad Event Queue with Indexed Peek

This block stores keypad press and release events until a host collects them over a byte-wide command bus. A matrix scanner offers one event per cycle as a key code plus a press/release flag. Each accepted event is packed into one byte and placed in a 16-entry circular store. The host's command decoder reads the store in one of two ways. A consuming read moves the head forward and returns the byte at the new head. A peek returns the byte at a chosen offset from the head and changes nothing.

A pulse tells the interrupt logic that an event was taken. When an event meets a full store, a sticky overflow flag is raised. From then on every new event is dropped silently until the clear input is applied. The clear input stands for the configuration command, and it empties the queue. Read data is registered: it appears on the cycle after the request and holds until the next request.

Top module: `keyq_top`

## Requirements
- R1: After synchronous reset the queue is empty, `ovf_flag` and `key_irq` are 0, and `rd_data` is 0x00.
- R2: A stored byte carries the key code in bits 6:0, with bit 7 = 1 for a press and 0 for a release.
- R3: An accepted event is written at slot (head + level) mod 16, and the level then grows by one, so entries keep arrival order across the wrap of the slot index.
- R4: When an event arrives with 16 entries already held, it is discarded, the stored bytes stay as they were, and `ovf_flag` reads 1 from the next cycle on.
- R5: While `ovf_flag` is 1, incoming events are ignored: no write, no level change and no `key_irq`, even after reads have freed space.
- R6: A consuming read (`rd_en`=1, `rd_peek`=0) returns 0x00 and changes nothing when the level is 0 or 1. Otherwise it advances the head by one (mod 16), lowers the level by one and returns the byte at the new head.
- R7: A peek (`rd_en`=1, `rd_peek`=1) at index i returns 0x00 when i >= level, and otherwise the byte at slot (head + i) mod 16. It changes no state.
- R8: Each accepted event gives a one-cycle `key_irq` pulse on the following cycle. No pulse is given for a dropped event.
- R9: `clr` sets head, level and `ovf_flag` to zero on the next edge. An event offered in the same cycle is dropped.
- R10: An accepted event and an advancing consuming read in the same cycle both take effect, and the level stays unchanged.
- R11: `rd_data` updates on the edge that samples `rd_en`=1 and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Configuration clear: empties the queue and drops overflow |
| ev_valid | input | 1 | Event offered this cycle |
| ev_code | input | 7 | Key code of the event |
| ev_press | input | 1 | 1 = press, 0 = release |
| rd_en | input | 1 | Read request this cycle |
| rd_peek | input | 1 | 1 = indexed peek, 0 = consuming read |
| rd_idx | input | 8 | Byte index for a peek |
| rd_data | output | 8 | Registered read result |
| key_irq | output | 1 | One-cycle pulse per accepted event |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
Several rules are checked by the bound checker on every cycle: the level bound, the interrupt pulse that follows each acceptance, the dropping of events while overflow is set, the empty-read rule, the level bookkeeping for a read on its own and for a read together with a write, the effect of clear, and the hold of read data. Other behaviour depends on what the queue holds, and only the scoreboard scenarios can show it. This covers the byte packing, arrival order across the wrap of the slot index, the shifted position returned by a consuming read, the zero returned by a peek past the fill level, and the fact that the stored bytes are left intact when events are dropped.

// File: rtl/keyq_pkg.sv
package keyq_pkg;
  parameter int KEYQ_CODE_W = 7;
  parameter int KEYQ_ENTRY_W = KEYQ_CODE_W + 1;

  // Modular slot arithmetic; mask is depth-1 for a power-of-two depth.
  function automatic logic [7:0] keyq_wrap_add(logic [7:0] a, logic [7:0] b, logic [7:0] mask);
    return (a + b) & mask;
  endfunction

  // Index lies inside the filled part of the queue.
  function automatic logic keyq_below(logic [15:0] idx, logic [15:0] lvl);
    return idx < lvl;
  endfunction

  // Entry byte: direction flag on top, code underneath.
  function automatic logic [KEYQ_ENTRY_W-1:0] keyq_pack(logic press, logic [KEYQ_CODE_W-1:0] code);
    return {press, code};
  endfunction
endpackage

// File: rtl/keyq_store.sv
module keyq_store #(
  parameter int DEPTH = 16,
  parameter int EW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) slot[g] <= wdata;
    end
  end

  assign rdata = slot[raddr];
endmodule

// File: rtl/keyq_ctrl.sv
module keyq_ctrl
  import keyq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ev_valid,
  input  logic          pop_req,
  output logic [AW-1:0] q_start,
  output logic [LW-1:0] q_len,
  output logic [AW-1:0] waddr,
  output logic          accept,
  output logic          ovf_hit,
  output logic          pop_ok,
  output logic          ovf_flag,
  output logic          key_irq
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [7:0] MASK = 8'(DEPTH - 1);

  logic full;
  assign full    = (q_len == FULL);
  assign accept  = ev_valid && !clr && !ovf_flag && !full;
  assign ovf_hit = ev_valid && !clr && !ovf_flag && full;
  assign pop_ok  = pop_req && !clr && (q_len > LW'(1));
  assign waddr   = AW'(keyq_wrap_add(8'(q_start), 8'(q_len), MASK));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q_start  <= '0;
      q_len    <= '0;
      ovf_flag <= 1'b0;
      key_irq  <= 1'b0;
    end else begin
      if (pop_ok) q_start <= AW'(keyq_wrap_add(8'(q_start), 8'd1, MASK));
      case ({accept, pop_ok})
        2'b10:   q_len <= q_len + 1'b1;
        2'b01:   q_len <= q_len - 1'b1;
        default: q_len <= q_len;
      endcase
      ovf_flag <= ovf_flag | ovf_hit;
      key_irq  <= accept;
    end
  end
endmodule

// File: rtl/keyq_rdport.sv
module keyq_rdport
  import keyq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 8,
  parameter int EW = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             rd_peek,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [AW-1:0]    q_start,
  input  logic [LW-1:0]    q_len,
  input  logic [EW-1:0]    mem_data,
  output logic [AW-1:0]    raddr,
  output logic [EW-1:0]    rd_data
);
  localparam logic [7:0] MASK = 8'(DEPTH - 1);

  logic in_fill;

  always_comb begin
    if (rd_peek) begin
      raddr   = AW'(keyq_wrap_add(8'(q_start), 8'(rd_idx[AW-1:0]), MASK));
      in_fill = keyq_below(16'(rd_idx), 16'(q_len));
    end else begin
      raddr   = AW'(keyq_wrap_add(8'(q_start), 8'd1, MASK));
      in_fill = (q_len > LW'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= in_fill ? mem_data : '0;
  end
endmodule

// File: rtl/keyq_top.sv
module keyq_top
  import keyq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    ev_valid,
  input  logic [KEYQ_CODE_W-1:0]  ev_code,
  input  logic                    ev_press,
  input  logic                    rd_en,
  input  logic                    rd_peek,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [KEYQ_ENTRY_W-1:0] rd_data,
  output logic                    key_irq,
  output logic                    ovf_flag
);
  // Internal events brought out by name for the checker.
  logic [AW-1:0] q_start;
  logic [LW-1:0] q_len;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic [KEYQ_ENTRY_W-1:0] mem_data;
  logic accept;
  logic ovf_hit;
  logic pop_ok;
  logic pop_req;

  assign pop_req = rd_en && !rd_peek;

  keyq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .clr(clr), .ev_valid(ev_valid), .pop_req(pop_req),
    .q_start(q_start), .q_len(q_len), .waddr(waddr), .accept(accept),
    .ovf_hit(ovf_hit), .pop_ok(pop_ok), .ovf_flag(ovf_flag), .key_irq(key_irq)
  );

  keyq_store #(.DEPTH(DEPTH), .EW(KEYQ_ENTRY_W)) u_store (
    .clk(clk), .we(accept), .waddr(waddr), .wdata(keyq_pack(ev_press, ev_code)),
    .raddr(raddr), .rdata(mem_data)
  );

  keyq_rdport #(.DEPTH(DEPTH), .IDX_W(IDX_W), .EW(KEYQ_ENTRY_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_peek(rd_peek), .rd_idx(rd_idx),
    .q_start(q_start), .q_len(q_len), .mem_data(mem_data),
    .raddr(raddr), .rd_data(rd_data)
  );
endmodule

// File: rtl/keyq_chk.sv
module keyq_chk #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic          rd_en,
  input logic          rd_peek,
  input logic [7:0]    rd_data,
  input logic          key_irq,
  input logic          ovf_flag,
  input logic [AW-1:0] q_start,
  input logic [LW-1:0] q_len,
  input logic          accept,
  input logic          ovf_hit,
  input logic          pop_ok
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
    q_len <= FULL);

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    accept |=> key_irq);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!accept && !clr) |=> !key_irq);

  assert_overflow_set_R4: assert property (@(posedge clk) disable iff (rst)
    ovf_hit |=> ovf_flag);

  assert_ovf_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> !accept);

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_peek && !clr && q_len <= LW'(1)) |=> (rd_data == 8'h00 && $stable(q_start)));

  assert_pop_level_R6: assert property (@(posedge clk) disable iff (rst)
    (pop_ok && !accept) |=> (q_len + 1'b1 == $past(q_len)));

  assert_push_pop_R10: assert property (@(posedge clk) disable iff (rst)
    (pop_ok && accept) |=> $stable(q_len));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q_len == '0 && q_start == '0 && !ovf_flag));

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind keyq_top keyq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .rd_en(rd_en), .rd_peek(rd_peek),
  .rd_data(rd_data), .key_irq(key_irq), .ovf_flag(ovf_flag),
  .q_start(q_start), .q_len(q_len), .accept(accept), .ovf_hit(ovf_hit),
  .pop_ok(pop_ok)
);

// File: tb/tb_keyq_top.sv
`timescale 1ns/1ps
module tb_keyq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       ev_valid = 1'b0;
  logic [6:0] ev_code = '0;
  logic       ev_press = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_peek = 1'b0;
  logic [7:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       key_irq;
  logic       ovf_flag;

  always #2.5 clk = ~clk;

  keyq_top dut (
    .clk(clk), .rst(rst), .clr(clr), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_press(ev_press), .rd_en(rd_en), .rd_peek(rd_peek), .rd_idx(rd_idx),
    .rd_data(rd_data), .key_irq(key_irq), .ovf_flag(ovf_flag)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model of the queue.
  logic [7:0] mdl [16];
  int  mstart = 0;
  int  mlen = 0;
  bit  movf = 1'b0;
  logic [7:0] last_rd = 8'h00;

  // Scoreboard of expected read results.
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: compares each read result on the cycle after its request.
  logic rd_d = 1'b0;
  always @(posedge clk) rd_d <= rd_en;
  always @(negedge clk) begin
    if (rd_d && !rst) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected read result", int'(rd_data), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, "rd_data", int'(rd_data), int'(e));
      end
    end
  end

  // One bus cycle with any mix of stimulus; updates the model and queues expectations.
  task automatic op(input bit ev, input logic [6:0] code, input bit pr,
                    input bit rd, input bit pk, input int idx, input bit cl, input string tag);
    bit acc, hit, pop;
    logic [7:0] er;
    er = 8'h00;
    if (rd) begin
      if (pk) er = (idx < mlen) ? mdl[(mstart + idx) % 16] : 8'h00;
      else    er = (mlen > 1) ? mdl[(mstart + 1) % 16] : 8'h00;
      exp_q.push_back(er);
      tag_q.push_back(tag);
      last_rd = er;
    end
    acc = ev && !cl && !movf && (mlen < 16);
    hit = ev && !cl && !movf && (mlen == 16);
    pop = rd && !pk && !cl && (mlen > 1);
    if (cl) begin
      mstart = 0; mlen = 0; movf = 1'b0;
    end else begin
      if (acc) mdl[(mstart + mlen) % 16] = {pr, code};
      mlen = mlen + int'(acc) - int'(pop);
      if (pop) mstart = (mstart + 1) % 16;
      if (hit) movf = 1'b1;
    end
    ev_valid = ev; ev_code = code; ev_press = pr;
    rd_en = rd; rd_peek = pk; rd_idx = 8'(idx); clr = cl;
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0; rd_en = 1'b0; clr = 1'b0;
    check(key_irq == acc, (tag == "R9") ? "R9" : "R8", "key_irq", int'(key_irq), int'(acc));
    check(ovf_flag == movf, "R4", "ovf_flag", int'(ovf_flag), int'(movf));
  endtask

  task automatic push(input logic [6:0] code, input bit pr, input string tag);
    op(1'b1, code, pr, 1'b0, 1'b0, 0, 1'b0, tag);
  endtask

  task automatic consume(input string tag);
    op(1'b0, 7'd0, 1'b0, 1'b1, 1'b0, 0, 1'b0, tag);
  endtask

  task automatic peek(input int idx, input string tag);
    op(1'b0, 7'd0, 1'b0, 1'b1, 1'b1, idx, 1'b0, tag);
  endtask

  task automatic peek_all(input string tag);
    for (int i = 0; i <= 17; i++) peek(i, tag);
    peek(200, "R7");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(ovf_flag == 1'b0, "R1", "ovf_flag", int'(ovf_flag), 0);
    check(key_irq == 1'b0, "R1", "key_irq", int'(key_irq), 0);
    check(rd_data == 8'h00, "R1", "rd_data", int'(rd_data), 0);
    peek(0, "R1");

    // R2/R3: packing and order
    push(7'h3c, 1'b1, "R2");
    push(7'h55, 1'b0, "R2");
    push(7'h01, 1'b1, "R3");
    peek_all("R2");

    // R6: consuming read returns the byte after the head
    consume("R6");
    peek_all("R7");
    consume("R6");
    consume("R6");   // level 1: returns zero, no change
    consume("R6");
    peek_all("R6");

    // R11: hold without request
    op(1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R11");
    op(1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R11");
    check(rd_data == last_rd, "R11", "rd_data hold", int'(rd_data), int'(last_rd));

    // R9: clear, with a simultaneous event dropped
    op(1'b1, 7'h22, 1'b1, 1'b0, 1'b0, 0, 1'b1, "R9");
    peek_all("R9");

    // R4: fill to 16, then overflow
    for (int i = 0; i < 16; i++) push(7'(i + 16), i[0], "R4");
    peek_all("R4");
    push(7'h7f, 1'b1, "R4");
    check(ovf_flag == 1'b1, "R4", "overflow raised", int'(ovf_flag), 1);
    peek_all("R4");

    // R5: drops continue after space is freed
    consume("R5");
    consume("R5");
    push(7'h44, 1'b1, "R5");
    push(7'h45, 1'b0, "R5");
    peek_all("R5");

    // R9: clear drops overflow
    op(1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 0, 1'b1, "R9");
    check(ovf_flag == 1'b0, "R9", "ovf after clear", int'(ovf_flag), 0);

    // R3: wrap of slot index
    for (int i = 0; i < 10; i++) push(7'(i + 64), 1'b1, "R3");
    for (int i = 0; i < 8; i++) consume("R3");
    for (int i = 0; i < 12; i++) push(7'(i + 96), i[1], "R3");
    peek_all("R3");

    // R10: push and consume together
    op(1'b1, 7'h11, 1'b1, 1'b1, 1'b0, 0, 1'b0, "R10");
    op(1'b1, 7'h12, 1'b0, 1'b1, 1'b0, 0, 1'b0, "R10");
    peek_all("R10");
    // R10 at level 1: push takes effect, read returns zero
    op(1'b0, 7'd0, 1'b0, 1'b0, 1'b0, 0, 1'b1, "R9");
    push(7'h05, 1'b1, "R10");
    op(1'b1, 7'h06, 1'b0, 1'b1, 1'b0, 0, 1'b0, "R10");
    peek_all("R10");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11", "pending reads", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule